// File: doc/BRIEF.md
# I2C Stop Request and Clock-Stretch Control

This block is the control slice of a byte-oriented I2C peripheral. It holds a one-byte control register. Two of its bits matter here: a stop-request bit and an interrupt-enable bit. From that register and the status flags of the bit engine, it decides three things: when a Stop condition is requested, when the bus lines are let go, and when SCL must be stretched low. The shift engine and the address matcher sit outside the block. They supply the status flags and a one-cycle pulse that reports a completed Stop.

The stop-request bit behaves differently in each mode. In master mode it asks for a Stop once a byte transfer or a Start condition has finished. Hardware clears the bit when the Stop has gone out. In slave mode it releases both lines after the current byte. The bit then stays set until software writes it back to 0. SCL is stretched while any status flag is pending, unless a slave release is in effect. The interrupt output is the interrupt-enable bit gated by the same set of flags.

Top module: `i2c_stop_stretch_ctrl`

## Requirements
- R1: After reset the control byte reads 8'h00, and stop_gen, line_release, scl_hold_low and irq are all 0.
- R2: A write (wr_en=1) stores wr_data into the control byte, which appears on rd_data on the next cycle. Bit 1 is the stop-request bit and bit 0 is the interrupt-enable bit. Bits 7:2 are stored and read back but have no effect.
- R3: stop_gen is 1 exactly when periph_en=1, master_mode=1, the stop-request bit is set, and status_flags[0] (Start sent) or status_flags[1] (byte transfer finished) is 1.
- R4: In master mode, a stop_sent pulse while the stop-request bit is set clears that bit on the next cycle, provided no write happens in the same cycle.
- R5: stop_sent has no effect on the control byte in slave mode (master_mode=0) or when the stop-request bit is already 0.
- R6: In slave mode with periph_en=1, the stop-request bit set and status_flags[1]=1, line_release goes to 1 on the next cycle. It stays at 1 until the stop-request bit is cleared. Hardware never clears the stop-request bit in slave mode.
- R7: While periph_en=0, the stop-request bit reads 0 from the next cycle on, even if a write sets it. The interrupt-enable bit and bits 7:2 keep their written values.
- R8: scl_hold_low is 1 exactly when periph_en=1, any of status_flags[4:0] is 1 and line_release is 0. The flags are: bit 0 Start sent, bit 1 byte transfer finished, bit 2 10-bit header sent, bit 3 address matched, bit 4 address-acknowledged event.
- R9: irq is 1 exactly when the interrupt-enable bit is 1 and any of status_flags[4:0] is 1. This holds regardless of periph_en.
- R10: When a write and a stop_sent pulse fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Current control byte |
| periph_en | input | 1 | Peripheral enable |
| master_mode | input | 1 | 1 = master, 0 = slave |
| status_flags | input | 5 | Pending status flags (bit map in R8) |
| stop_sent | input | 1 | One-cycle pulse: Stop condition completed |
| stop_gen | output | 1 | Request to drive a Stop condition |
| line_release | output | 1 | Slave request to release SCL and SDA |
| scl_hold_low | output | 1 | Stretch SCL low |
| irq | output | 1 | Gated interrupt request |

## Verification
Some rules are checked by assertions on every cycle. Those rules are:
- the hardware clear after a master Stop;
- a stop_sent pulse leaving the control byte untouched in slave mode;
- the forced clear while the peripheral is disabled;
- the interrupt-enable bit being kept;
- a write winning over a clear in the same cycle;
- a release only ever coming with the stop-request bit set;
- the stretch being suppressed during a release;
- the interrupt gating.

The exact levels of the combinational outputs under each mix of flags and modes show only in the bench scenarios. So do the full master and slave sequences and the read-back of the stored byte. A release that persists across changing flags, and the return to the reset state, are likewise shown there.

// File: rtl/i2cscs_pkg.sv
package i2cscs_pkg;
    localparam int REG_W     = 8;
    localparam int STOP_POS  = 1;
    localparam int IE_POS    = 0;
    localparam int NUM_FLAGS = 5;
    localparam int FLG_START = 0;
    localparam int FLG_BTF   = 1;
    localparam int FLG_HDR10 = 2;
    localparam int FLG_ADDR  = 3;
    localparam int FLG_ACK   = 4;

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } ctrl_state_t;

    typedef struct packed {
        logic rel;
    } rel_state_t;
endpackage

// File: rtl/i2cscs_ctrl_reg.sv
module i2cscs_ctrl_reg
    import i2cscs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             periph_en,
    input  logic             master_mode,
    input  logic             stop_sent,
    output logic [REG_W-1:0] ctrl_q,
    output logic             stop_q,
    output logic             stop_d,
    output logic             ie_q
);
    ctrl_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (master_mode && st_q.bits[STOP_POS] && stop_sent)
            st_d.bits[STOP_POS] = 1'b0;
        if (wr_en)
            st_d.bits = wr_data;
        if (!periph_en)
            st_d.bits[STOP_POS] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.bits;
    assign stop_q = st_q.bits[STOP_POS];
    assign stop_d = st_d.bits[STOP_POS];
    assign ie_q   = st_q.bits[IE_POS];

    // R4: master hardware clear after Stop sent
    p_hw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && stop_q && stop_sent && !wr_en) |=> !stop_q);
    // R5: stop_sent leaves the byte alone in slave mode
    p_slave_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sent && !master_mode && !wr_en && periph_en) |=> ctrl_q == $past(ctrl_q));
    // R6: no hardware clear in slave mode
    p_slave_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !master_mode && periph_en && stop_q) |=> stop_q);
    // R7: disable forces stop off, enable bit kept
    p_en_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> !stop_q);
    p_ie_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ie_q == $past(ie_q));
    // R10: write beats a same-cycle clear
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && periph_en) |=> ctrl_q == $past(wr_data));
endmodule

// File: rtl/i2cscs_release.sv
module i2cscs_release
    import i2cscs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic periph_en,
    input  logic master_mode,
    input  logic stop_q,
    input  logic stop_d,
    input  logic byte_done,
    output logic release_q
);
    rel_state_t st_q, st_d;
    logic arm;

    always_comb begin
        arm      = periph_en && !master_mode && stop_q && byte_done;
        st_d.rel = stop_d && (st_q.rel || arm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign release_q = st_q.rel;

    // R6: slave release follows a finished byte and needs stop set
    p_rel_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && !master_mode && stop_q && byte_done && stop_d) |=> release_q);
    p_rel_needs_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        release_q |-> stop_q);
endmodule

// File: rtl/i2cscs_flag_gate.sv
module i2cscs_flag_gate
    import i2cscs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 periph_en,
    input  logic                 master_mode,
    input  logic                 stop_q,
    input  logic                 ie_q,
    input  logic                 release_q,
    output logic                 stop_gen,
    output logic                 scl_hold_low,
    output logic                 irq
);
    logic any_pending;
    logic stop_point;

    always_comb begin
        any_pending  = |flags;
        stop_point   = flags[FLG_START] | flags[FLG_BTF];
        stop_gen     = periph_en && master_mode && stop_q && stop_point;
        scl_hold_low = periph_en && any_pending && !release_q;
        irq          = ie_q && any_pending;
    end

    // R3: stop request only in enabled master mode
    p_gen_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_gen |-> (master_mode && periph_en && stop_q));
    // R8: release suppresses stretching
    p_hold_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_q |-> !scl_hold_low);
    // R9: no interrupt without enable
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
endmodule

// File: rtl/i2c_stop_stretch_ctrl.sv
module i2c_stop_stretch_ctrl
    import i2cscs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 periph_en,
    input  logic                 master_mode,
    input  logic [NUM_FLAGS-1:0] status_flags,
    input  logic                 stop_sent,
    output logic                 stop_gen,
    output logic                 line_release,
    output logic                 scl_hold_low,
    output logic                 irq
);
    logic stop_q, stop_d, ie_q, release_q;

    i2cscs_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .periph_en(periph_en), .master_mode(master_mode), .stop_sent(stop_sent),
        .ctrl_q(rd_data), .stop_q(stop_q), .stop_d(stop_d), .ie_q(ie_q)
    );

    i2cscs_release u_rel (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .master_mode(master_mode),
        .stop_q(stop_q), .stop_d(stop_d), .byte_done(status_flags[FLG_BTF]),
        .release_q(release_q)
    );

    i2cscs_flag_gate u_gate (
        .clk(clk), .rst_n(rst_n), .flags(status_flags), .periph_en(periph_en),
        .master_mode(master_mode), .stop_q(stop_q), .ie_q(ie_q),
        .release_q(release_q), .stop_gen(stop_gen),
        .scl_hold_low(scl_hold_low), .irq(irq)
    );

    assign line_release = release_q;
endmodule

// File: tb/sim_i2c_stop_stretch_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_stop_stretch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       periph_en = 1'b0;
    logic       master_mode = 1'b0;
    logic [4:0] status_flags = '0;
    logic       stop_sent = 1'b0;
    logic       stop_gen, line_release, scl_hold_low, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    i2c_stop_stretch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .periph_en(periph_en), .master_mode(master_mode), .status_flags(status_flags),
        .stop_sent(stop_sent), .stop_gen(stop_gen), .line_release(line_release),
        .scl_hold_low(scl_hold_low), .irq(irq)
    );

    // row: we, wd[8], en, ms, flags[5] (b0 start,b1 btf,b2 hdr10,b3 addr,b4 ack), ss,
    //      exp rd[8], exp {stop_gen, line_release, scl_hold_low, irq}
    localparam int NV = 15;
    localparam logic [28:0] TBL [NV] = '{
        {1'b1, 8'hA1, 1'b1, 1'b1, 5'b00000, 1'b0, 8'hA1, 4'b0000}, // R2 store
        {1'b1, 8'hA3, 1'b1, 1'b1, 5'b00000, 1'b0, 8'hA3, 4'b0000}, // R2 stop set
        {1'b0, 8'h00, 1'b1, 1'b1, 5'b00010, 1'b0, 8'hA3, 4'b1011}, // R3 after byte
        {1'b0, 8'h00, 1'b1, 1'b1, 5'b00001, 1'b1, 8'hA1, 4'b0011}, // R4 hw clear
        {1'b0, 8'h00, 1'b1, 1'b1, 5'b00000, 1'b1, 8'hA1, 4'b0000}, // R5 stop already 0
        {1'b1, 8'h02, 1'b1, 1'b0, 5'b00000, 1'b0, 8'h02, 4'b0000}, // R2 slave stop
        {1'b0, 8'h00, 1'b1, 1'b0, 5'b00010, 1'b1, 8'h02, 4'b0100}, // R6 release, R5
        {1'b0, 8'h00, 1'b1, 1'b0, 5'b01000, 1'b0, 8'h02, 4'b0100}, // R6 held, R8
        {1'b1, 8'h01, 1'b1, 1'b0, 5'b01000, 1'b0, 8'h01, 4'b0011}, // R6 sw clear, R9
        {1'b1, 8'h03, 1'b0, 1'b1, 5'b10000, 1'b0, 8'h01, 4'b0001}, // R7 forced, R8, R9
        {1'b0, 8'h00, 1'b0, 1'b1, 5'b00000, 1'b0, 8'h01, 4'b0000}, // R7 ie kept
        {1'b1, 8'h03, 1'b1, 1'b1, 5'b00100, 1'b0, 8'h03, 4'b0011}, // R3 hdr10 no gen
        {1'b1, 8'h03, 1'b1, 1'b1, 5'b00000, 1'b1, 8'h03, 4'b0000}, // R10 write wins
        {1'b0, 8'h00, 1'b1, 1'b1, 5'b00001, 1'b0, 8'h03, 4'b1011}, // R3 after start
        {1'b0, 8'h00, 1'b0, 1'b1, 5'b00001, 1'b0, 8'h01, 4'b0001}  // R7 disable
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {rd_data, stop_gen, line_release, scl_hold_low, irq}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {rd_data, stop_gen, line_release, scl_hold_low, irq}, 12'h000);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = TBL[i];
            wr_en        = v[28];
            wr_data      = v[27:20];
            periph_en    = v[19];
            master_mode  = v[18];
            status_flags = v[17:13];
            stop_sent    = v[12];
            @(negedge clk);
            wr_en     = 1'b0;
            stop_sent = 1'b0;
            check($sformatf("R-table row %0d", i),
                  {rd_data, stop_gen, line_release, scl_hold_low, irq}, v[11:0]);
        end

        // R6: release persists through flag changes until software clears
        periph_en = 1'b1; master_mode = 1'b0; status_flags = 5'b00000;
        wr_en = 1'b1; wr_data = 8'h02; @(negedge clk); wr_en = 1'b0;
        status_flags = 5'b00010; @(negedge clk);
        status_flags = 5'b00000;
        repeat (4) @(negedge clk);
        check("R6 release held", {11'h0, line_release}, 12'h001);
        check("R6 stop kept", {4'h0, rd_data}, 12'h002);
        // R7: disable drops stop and release
        periph_en = 1'b0; @(negedge clk);
        check("R7 release dropped", {rd_data, stop_gen, line_release, scl_hold_low, irq}, 12'h000);

        // R1: mid-run reset
        periph_en = 1'b1; wr_en = 1'b1; wr_data = 8'hFF; @(negedge clk); wr_en = 1'b0;
        status_flags = 5'b00001; master_mode = 1'b1;
        rst_n = 1'b0; @(negedge clk);
        check("R1 reset mid-run rd", {4'h0, rd_data}, 12'h000);
        check("R9 irq off after reset", {11'h0, irq}, 12'h000);
        rst_n = 1'b1; status_flags = '0; @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule